// File: doc/BRIEF.md
# Encoder Edge Period and Rate Meter

This block turns a stream of pre-synchronized rising-edge pulses from encoder track A into two measurements. The first is the period: the number of time-base ticks between two consecutive rising edges. If no edge arrives within a limit, the period is withdrawn. The second is the edge rate: rising edges counted over a configurable window, scaled by a tick-rate constant, and divided by the elapsed ticks in a multi-cycle sequential divider. The result is the number of edges per second, which is never negative.

Short windows are edge-aligned. Such a window opens on a rising edge. When its length has elapsed, it stays open until the next rising edge, or until a wait limit expires, so the measurement covers whole periods. Long windows open and close on time alone. A gate that blocks the position counter stops the rate measurement but not the period measurement. A zero-mark or external counter reset restarts the rate measurement, and the last result is held until a new one exists.

The tick strobe normally runs at 10 MHz, one tick every 100 ns. All time constants are parameters, so the same logic also serves other time bases.

Top module: `enc_rate_meter`

## Requirements
- R1: After reset, period, period_valid, freq, freq_valid and freq_done are all zero.
- R2: On a rising-edge pulse that follows an earlier accepted edge, period becomes the number of tick strobes seen after the earlier edge's cycle, up to and including the new edge's cycle, and period_valid is set.
- R3: If the tick count since the last edge reaches the active limit with no edge, period_valid and period drop to zero. The first edge after that only re-arms the measurement and reports nothing.
- R4: The active period limit is PERIOD_LIMIT ticks when cfg_long_period is 0, and twice that when it is 1.
- R5: In edge-aligned mode the window opens on a rising edge. freq becomes floor(edges × FREQ_SCALE / elapsed), where edges and elapsed count from after the opening edge up to and including the closing edge. The closing edge also opens the next window.
- R6: If no edge arrives after an edge-aligned window has expired, the measurement is abandoned after min(PERIOD_LIMIT, cfg_wait_ms × TICKS_PER_MS) ticks of waiting. freq then becomes 0 with a done pulse.
- R7: The window length in ticks is cfg_win_len × TICKS_PER_MS when cfg_win_ms is 1, and cfg_win_len × TICKS_PER_US when it is 0. A length of 0 counts as 1.
- R8: When cfg_win_ms is 1 and cfg_win_len is greater than LONG_WIN_MS, windows follow one another immediately, each exactly one window long, with no arming edge and no wait. freq is then the edges in that window × FREQ_SCALE / window ticks.
- R9: While gate_block is high, no rate result is produced and freq is held, but period keeps being measured.
- R10: A meas_restart pulse abandons the window in progress. freq and freq_valid keep their values until the next result.
- R11: Every new result raises freq_done for one cycle, together with the new freq value, and sets freq_valid, which then stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base strobe, one per tick |
| a_rise | input | 1 | One-cycle pulse per rising edge of track A |
| gate_block | input | 1 | High while the position counter is gated off |
| meas_restart | input | 1 | Pulse on a zero-mark or external counter reset |
| cfg_long_period | input | 1 | Selects the doubled period limit |
| cfg_win_ms | input | 1 | Window unit: 1 = milliseconds, 0 = microseconds |
| cfg_win_len | input | WLEN_W | Window length in units |
| cfg_wait_ms | input | WAIT_W | Wait limit for the closing edge, in ms |
| period | output | CNT_W | Ticks between the last two rising edges |
| period_valid | output | 1 | period holds a live measurement |
| freq | output | CNT_W | Edges per second |
| freq_valid | output | 1 | At least one rate result exists |
| freq_done | output | 1 | One-cycle strobe when a new rate result is ready |

## Verification
On every cycle, the assertions check the following. Each divider result satisfies quotient × divisor + remainder = dividend. The rate output never changes without a done strobe. A high gate forces the window logic idle. The wait counter stays below its limit. The period stays within the doubled limit, and it appears or disappears only in step with edges or their absence. The exact rate values, the window lengths seen as the spacing between done strobes, the waiting cap, the long-window behaviour with no motion, and the restart delay can only be shown by the bench's scenarios, which compare timings and values with numbers worked out in advance.

// File: rtl/erm_pkg.sv
package erm_pkg;
   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_ARM  = 2'd1,
      FS_OPEN = 2'd2,
      FS_WAIT = 2'd3
   } fstate_e;
endpackage

// File: rtl/erm_period_unit.sv
module erm_period_unit #(
   parameter int CNT_W        = 32,
   parameter int PERIOD_LIMIT = 16000000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             a_rise,
   input  logic             long_sel,
   output logic [CNT_W-1:0] period,
   output logic             period_valid
);
   localparam logic [CNT_W-1:0] LIM_S = CNT_W'(PERIOD_LIMIT);
   localparam logic [CNT_W-1:0] LIM_L = CNT_W'(2 * PERIOD_LIMIT);

   logic [CNT_W-1:0] lim, cnt_q, cnt_n;
   logic             armed_q;

   assign lim   = long_sel ? LIM_L : LIM_S;
   assign cnt_n = (cnt_q >= lim) ? cnt_q : cnt_q + CNT_W'(tick);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q        <= '0;
         armed_q      <= 1'b0;
         period       <= '0;
         period_valid <= 1'b0;
      end else if (a_rise) begin
         if (armed_q) begin
            period       <= cnt_n;
            period_valid <= 1'b1;
         end
         cnt_q   <= '0;
         armed_q <= 1'b1;
      end else if (cnt_n >= lim) begin
         cnt_q <= cnt_n;
         if (armed_q) begin
            armed_q      <= 1'b0;
            period       <= '0;
            period_valid <= 1'b0;
         end
      end else begin
         cnt_q <= cnt_n;
      end
   end

   assert_period_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      period_valid |-> period <= LIM_L);
   assert_valid_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(period_valid) |-> $past(a_rise));
   assert_cancel_no_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(period_valid) |-> !$past(a_rise));
endmodule

// File: rtl/erm_seq_div.sv
module erm_seq_div #(
   parameter int NUM_W = 56,
   parameter int DEN_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             busy,
   output logic             done,
   output logic [NUM_W-1:0] quo
);
   localparam int CW = $clog2(NUM_W + 1);
   localparam int PW = NUM_W + DEN_W;

   logic [DEN_W-1:0] rem_q, den_q, rem_n;
   logic [NUM_W-1:0] num_q;
   logic [CW-1:0]    cnt_q;
   logic [DEN_W:0]   partial, diff;
   logic             ge;

   assign partial = {rem_q, quo[NUM_W-1]};
   assign diff    = partial - {1'b0, den_q};
   assign ge      = partial >= {1'b0, den_q};
   assign rem_n   = ge ? diff[DEN_W-1:0] : partial[DEN_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quo   <= '0;
         rem_q <= '0;
         den_q <= '0;
         num_q <= '0;
         cnt_q <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            quo   <= num;
            num_q <= num;
            den_q <= den;
            rem_q <= '0;
            cnt_q <= CW'(NUM_W);
            busy  <= 1'b1;
         end else if (busy) begin
            quo   <= {quo[NUM_W-2:0], ge};
            rem_q <= rem_n;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assert_div_exact_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && den_q != '0) |->
         ((PW'(quo) * PW'(den_q) + PW'(rem_q)) == PW'(num_q)) && (rem_q < den_q));
endmodule

// File: rtl/erm_freq_unit.sv
module erm_freq_unit
   import erm_pkg::*;
#(
   parameter int CNT_W        = 32,
   parameter int WLEN_W       = 16,
   parameter int WAIT_W       = 11,
   parameter int TICKS_PER_US = 10,
   parameter int TICKS_PER_MS = 10000,
   parameter int PERIOD_LIMIT = 16000000,
   parameter int LONG_WIN_MS  = 600,
   parameter int FREQ_SCALE   = 10000000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              a_rise,
   input  logic              gate_block,
   input  logic              meas_restart,
   input  logic              cfg_win_ms,
   input  logic [WLEN_W-1:0] cfg_win_len,
   input  logic [WAIT_W-1:0] cfg_wait_ms,
   output logic [CNT_W-1:0]  freq,
   output logic              freq_valid,
   output logic              freq_done
);
   localparam int SCALE_W = $clog2(FREQ_SCALE + 1);
   localparam int NUM_W   = CNT_W + SCALE_W;
   localparam logic [CNT_W-1:0] TPU_C = CNT_W'(TICKS_PER_US);
   localparam logic [CNT_W-1:0] TPM_C = CNT_W'(TICKS_PER_MS);
   localparam logic [CNT_W-1:0] LIM_C = CNT_W'(PERIOD_LIMIT);

   fstate_e          st_q, st_d;
   logic [CNT_W-1:0] el_q, el_d, el_n, ed_q, ed_d, ed_n, wc_q, wc_d, wc_n;
   logic [CNT_W-1:0] win_ticks, wait_raw, wait_lim;
   logic [WLEN_W-1:0] len_eff;
   logic             mode_b, close, tmo;
   logic             div_busy, div_done;
   logic [NUM_W-1:0] div_num, div_quo;

   assign len_eff   = (cfg_win_len == '0) ? WLEN_W'(1) : cfg_win_len;
   assign win_ticks = CNT_W'(len_eff) * (cfg_win_ms ? TPM_C : TPU_C);
   assign wait_raw  = CNT_W'(cfg_wait_ms) * TPM_C;
   assign wait_lim  = (wait_raw < LIM_C) ? wait_raw : LIM_C;
   assign mode_b    = cfg_win_ms && (cfg_win_len > WLEN_W'(LONG_WIN_MS));

   assign el_n = el_q + CNT_W'(tick);
   assign ed_n = ed_q + CNT_W'(a_rise);
   assign wc_n = wc_q + CNT_W'(tick);

   always_comb begin
      st_d  = st_q;
      el_d  = el_q;
      ed_d  = ed_q;
      wc_d  = wc_q;
      close = 1'b0;
      tmo   = 1'b0;
      if (gate_block) begin
         st_d = FS_IDLE;
         el_d = '0; ed_d = '0; wc_d = '0;
      end else if (meas_restart || st_q == FS_IDLE) begin
         st_d = mode_b ? FS_OPEN : FS_ARM;
         el_d = '0; ed_d = '0; wc_d = '0;
      end else begin
         case (st_q)
            FS_ARM: if (a_rise) st_d = FS_OPEN;
            FS_OPEN: begin
               if (el_n >= win_ticks) begin
                  if (mode_b || a_rise) begin
                     close = 1'b1;
                     el_d  = '0;
                     ed_d  = '0;
                  end else begin
                     st_d = FS_WAIT;
                     el_d = el_n;
                     ed_d = ed_n;
                     wc_d = '0;
                  end
               end else begin
                  el_d = el_n;
                  ed_d = ed_n;
               end
            end
            FS_WAIT: begin
               if (a_rise) begin
                  close = 1'b1;
                  st_d  = FS_OPEN;
                  el_d = '0; ed_d = '0; wc_d = '0;
               end else if (wc_n >= wait_lim) begin
                  tmo  = 1'b1;
                  st_d = FS_ARM;
                  el_d = '0; ed_d = '0; wc_d = '0;
               end else begin
                  el_d = el_n;
                  wc_d = wc_n;
               end
            end
            default: st_d = FS_IDLE;
         endcase
      end
   end

   assign div_num = NUM_W'(ed_n) * NUM_W'(FREQ_SCALE);

   erm_seq_div #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (close && !div_busy),
      .num   (div_num),
      .den   (el_n),
      .busy  (div_busy),
      .done  (div_done),
      .quo   (div_quo)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= FS_IDLE;
         el_q       <= '0;
         ed_q       <= '0;
         wc_q       <= '0;
         freq       <= '0;
         freq_valid <= 1'b0;
         freq_done  <= 1'b0;
      end else begin
         st_q <= st_d;
         el_q <= el_d;
         ed_q <= ed_d;
         wc_q <= wc_d;
         if (div_done) begin
            freq       <= (|div_quo[NUM_W-1:CNT_W]) ? '1 : div_quo[CNT_W-1:0];
            freq_valid <= 1'b1;
            freq_done  <= 1'b1;
         end else if (tmo) begin
            freq       <= '0;
            freq_valid <= 1'b1;
            freq_done  <= 1'b1;
         end else begin
            freq_done <= 1'b0;
         end
      end
   end

   assert_gate_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(gate_block) |-> st_q == FS_IDLE);
   assert_hold_value_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !freq_done |-> $stable(freq));
   assert_valid_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(freq_valid) |-> freq_valid);
   assert_wait_capped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == FS_WAIT && $stable(wait_lim)) |-> wc_q < wait_lim);
endmodule

// File: rtl/enc_rate_meter.sv
module enc_rate_meter #(
   parameter int CNT_W          = 32,
   parameter int WLEN_W         = 16,
   parameter int WAIT_W         = 11,
   parameter int TICKS_PER_US   = 10,
   parameter int TICKS_PER_MS   = 10000,
   parameter int PERIOD_LIMIT   = 16000000,
   parameter int LONG_WIN_MS    = 600,
   parameter int FREQ_SCALE     = 10000000,
   parameter int LONG_PERIOD_EN = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              a_rise,
   input  logic              gate_block,
   input  logic              meas_restart,
   input  logic              cfg_long_period,
   input  logic              cfg_win_ms,
   input  logic [WLEN_W-1:0] cfg_win_len,
   input  logic [WAIT_W-1:0] cfg_wait_ms,
   output logic [CNT_W-1:0]  period,
   output logic              period_valid,
   output logic [CNT_W-1:0]  freq,
   output logic              freq_valid,
   output logic              freq_done
);
   localparam longint SPAN    = longint'(1) << CNT_W;
   localparam longint MAX_WIN = ((longint'(1) << WLEN_W) - 1) * longint'(TICKS_PER_MS);

   if (CNT_W < 8 || CNT_W > 48) begin : g_bad_cnt_w
      $error("CNT_W out of supported range");
   end
   if (2 * longint'(PERIOD_LIMIT) >= SPAN) begin : g_bad_limit
      $error("doubled period limit does not fit CNT_W");
   end
   if (MAX_WIN + longint'(PERIOD_LIMIT) >= SPAN) begin : g_bad_window
      $error("longest window plus wait does not fit CNT_W");
   end
   if (TICKS_PER_US < 1 || TICKS_PER_MS < TICKS_PER_US || FREQ_SCALE < 1) begin : g_bad_time
      $error("time base parameters inconsistent");
   end

   logic long_sel;
   if (LONG_PERIOD_EN != 0) begin : g_long
      assign long_sel = cfg_long_period;
   end else begin : g_short
      assign long_sel = 1'b0;
   end

   erm_period_unit #(.CNT_W(CNT_W), .PERIOD_LIMIT(PERIOD_LIMIT)) u_period (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .a_rise       (a_rise),
      .long_sel     (long_sel),
      .period       (period),
      .period_valid (period_valid)
   );

   erm_freq_unit #(
      .CNT_W(CNT_W), .WLEN_W(WLEN_W), .WAIT_W(WAIT_W),
      .TICKS_PER_US(TICKS_PER_US), .TICKS_PER_MS(TICKS_PER_MS),
      .PERIOD_LIMIT(PERIOD_LIMIT), .LONG_WIN_MS(LONG_WIN_MS),
      .FREQ_SCALE(FREQ_SCALE)
   ) u_freq (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .a_rise       (a_rise),
      .gate_block   (gate_block),
      .meas_restart (meas_restart),
      .cfg_win_ms   (cfg_win_ms),
      .cfg_win_len  (cfg_win_len),
      .cfg_wait_ms  (cfg_wait_ms),
      .freq         (freq),
      .freq_valid   (freq_valid),
      .freq_done    (freq_done)
   );
endmodule

// File: tb/enc_rate_meter_tb.sv
module enc_rate_meter_tb;
   localparam int CW = 32;
   // stimulus/expectation rows: edge period, window (us), freq, period, done spacing
   localparam int VEC [0:4][0:4] = '{
      '{5,  20, 200, 5,  80},
      '{7,  20, 142, 7,  84},
      '{10, 25, 100, 10, 100},
      '{3,  30, 333, 3,  120},
      '{13, 20, 76,  13, 91}
   };

   logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, a_rise = 1'b0;
   logic gate_block = 1'b0, meas_restart = 1'b0, cfg_long_period = 1'b0, cfg_win_ms = 1'b0;
   logic [15:0] cfg_win_len = 16'd20;
   logic [10:0] cfg_wait_ms = 11'd10;
   logic [CW-1:0] period, freq;
   logic period_valid, freq_valid, freq_done;

   int n_chk = 0, n_bad = 0, cyc = 0, gen_p = 10, gcnt = 0;
   logic gen_en = 1'b0, tick_alt = 1'b0;

   enc_rate_meter #(
      .TICKS_PER_US(4), .TICKS_PER_MS(40), .PERIOD_LIMIT(100),
      .LONG_WIN_MS(6), .FREQ_SCALE(1000)
   ) u_dut (.*);

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (!gen_en) begin
         gcnt   <= 0;
         a_rise <= 1'b0;
      end else if (gcnt >= gen_p - 1) begin
         gcnt   <= 0;
         a_rise <= 1'b1;
      end else begin
         gcnt   <= gcnt + 1;
         a_rise <= 1'b0;
      end
      tick <= tick_alt ? ~tick : 1'b1;
   end

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_done();
      step(1);
      while (!freq_done) step(1);
   endtask

   task automatic pulse_restart();
      meas_restart = 1'b1;
      step(1);
      meas_restart = 1'b0;
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      report();
   end

   initial begin
      int t0, t1, t2, cnt_d;
      step(4);
      chk("R1 period", period, 0);
      chk("R1 period_valid", period_valid, 0);
      chk("R1 freq", freq, 0);
      chk("R1 freq_valid", freq_valid, 0);
      chk("R1 freq_done", freq_done, 0);
      rst_n = 1'b1;
      gen_en = 1'b1;

      // R5 / R7 / R2 table: edge-aligned windows in microsecond units
      for (int i = 0; i < 5; i++) begin
         gen_p = VEC[i][0];
         cfg_win_len = 16'(VEC[i][1]);
         pulse_restart();
         wait_done();
         wait_done();
         t1 = cyc;
         wait_done();
         t2 = cyc;
         chk("R5 freq edge-aligned", freq, VEC[i][2]);
         chk("R7 done spacing", t2 - t1, VEC[i][4]);
         chk("R2 period", period, VEC[i][3]);
         chk("R11 freq_valid", freq_valid, 1);
         step(1);
         chk("R11 done one cycle", freq_done, 0);
      end

      // R7: millisecond unit, 3 ms = 120 ticks, edges every 20
      cfg_win_ms = 1'b1; cfg_win_len = 16'd3; gen_p = 20;
      pulse_restart();
      wait_done(); wait_done(); t1 = cyc; wait_done(); t2 = cyc;
      chk("R7 ms window spacing", t2 - t1, 120);
      chk("R7 ms window freq", freq, 50);

      // R8: long window (8 ms > 6) = 320 ticks, fixed timing
      cfg_win_len = 16'd8; gen_p = 8;
      pulse_restart();
      wait_done(); wait_done(); t1 = cyc; wait_done(); t2 = cyc;
      chk("R8 long window freq", freq, 125);
      chk("R8 long window spacing", t2 - t1, 320);
      gen_en = 1'b0;
      wait_done(); wait_done(); t1 = cyc; wait_done(); t2 = cyc;
      chk("R8 no motion freq", freq, 0);
      chk("R8 no motion spacing", t2 - t1, 320);

      // R6: wait for closing edge capped by cfg_wait_ms (1 ms = 40 ticks)
      cfg_win_ms = 1'b0; cfg_win_len = 16'd20; cfg_wait_ms = 11'd1; gen_p = 10; gen_en = 1'b1;
      pulse_restart();
      wait_done(); wait_done();
      chk("R6 running freq", freq, 100);
      gen_en = 1'b0; t0 = cyc;
      wait_done();
      chk("R6 timeout freq zero", freq, 0);
      chk("R6 short wait bound", ((cyc - t0) >= 70 && (cyc - t0) <= 85) ? 1 : 0, 1);
      // R6: 10 ms wait is capped at the 100-tick limit
      cfg_wait_ms = 11'd10; gen_en = 1'b1;
      pulse_restart();
      wait_done(); wait_done();
      gen_en = 1'b0; t0 = cyc;
      wait_done();
      chk("R6 capped timeout freq", freq, 0);
      chk("R6 capped wait bound", ((cyc - t0) >= 130 && (cyc - t0) <= 145) ? 1 : 0, 1);

      // R9: gate blocks rate results but not the period
      gen_p = 10; gen_en = 1'b1;
      pulse_restart();
      wait_done(); wait_done();
      gate_block = 1'b1; gen_p = 20;
      step(60);
      cnt_d = 0;
      for (int k = 0; k < 300; k++) begin
         step(1);
         if (freq_done) cnt_d++;
      end
      chk("R9 no result while gated", cnt_d, 0);
      chk("R9 freq held while gated", freq, 100);
      chk("R9 period while gated", period, 20);
      chk("R9 period_valid while gated", period_valid, 1);
      gate_block = 1'b0;
      wait_done(); wait_done();
      chk("R9 freq after gate", freq, 50);

      // R10: restart abandons the window and holds the value
      pulse_restart();
      cnt_d = 0;
      for (int k = 0; k < 100; k++) begin
         if (freq_done) cnt_d++;
         step(1);
      end
      chk("R10 no result soon after restart", cnt_d, 0);
      chk("R10 freq held", freq, 50);
      chk("R10 freq_valid held", freq_valid, 1);
      wait_done();
      chk("R10 freq after restart", freq, 50);

      // R3 / R4: period limit and its doubled option
      gen_p = 150; cfg_long_period = 1'b0;
      step(500);
      chk("R3 period_valid cancelled", period_valid, 0);
      chk("R3 period cleared", period, 0);
      cfg_long_period = 1'b1;
      step(500);
      chk("R4 long period valid", period_valid, 1);
      chk("R4 long period value", period, 150);

      // R2: only tick strobes are counted
      cfg_long_period = 1'b0; gen_p = 10; tick_alt = 1'b1;
      step(100);
      chk("R2 period with half-rate ticks", period, 5);
      tick_alt = 1'b0;

      report();
   end
endmodule